// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block watches a set of asynchronous external interrupt pins and turns each into an interrupt request for a downstream interrupt controller. Every pin is first brought into the clock domain through a two-stage synchronizer. Its request is then formed from the synchronized level, or from the change between the current and the previous synchronized sample, according to a per-pin trigger mode.

The trigger modes live in a single configuration word that software writes as a whole and reads back unchanged. A driver that wants to retarget one pin reads the word, edits that pin's field and writes it back. For this to work, every mode field returns exactly what was last written, and the spare bit in each slot always reads zero. Level modes hold the request for as long as the condition lasts. Edge modes produce a one-cycle pulse for each qualifying transition. Changing a mode does not by itself create a pulse.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset the configuration word reads 0, so every pin is in low-level mode, and with all pins held low every request bit is 1.
- R2: Pin i owns the mode field at bits [4i+2:4i]. Bit 4i+3 always reads 0, and a value written to it is discarded.
- R3: A write (cfg_wr_en high at a clock edge) replaces all mode fields from cfg_wdata, and the new value is readable from the next cycle. Without a write the word holds, so a read-modify-write of one field leaves every other field unchanged.
- R4: Mode 000 (low level) drives the request high for every cycle in which the synchronized pin is 0.
- R5: Mode 001 (high level) drives the request high for every cycle in which the synchronized pin is 1.
- R6: Modes 010 and 011 (falling edge) give exactly one single-cycle pulse per 1-to-0 transition of the synchronized pin.
- R7: Modes 100 and 101 (rising edge) give exactly one single-cycle pulse per 0-to-1 transition of the synchronized pin.
- R8: Modes 110 and 111 (both edges) give one single-cycle pulse for each transition in either direction.
- R9: A pin value present at clock edge n is reflected in the request after edge n+1, so a level request follows the pin two edges late.
- R10: A pin that has not changed for the last two synchronized samples never produces a request in any edge mode, including across a mode change.
- R11: Pins are independent: each request depends only on its own pin and its own mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_in | input | NUM_PINS (8) | Asynchronous external interrupt pins |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | NUM_PINS*SLOT_W (32) | Configuration write data |
| cfg_rd_data | output | NUM_PINS*SLOT_W (32) | Current configuration word |
| irq_req | output | NUM_PINS (8) | Per-pin interrupt request, level or one-cycle pulse |

## Verification
The assertions relating requests to pin history compare against the pin value two and three edges earlier. They therefore assume that the pins are stable around each rising clock edge, and that enough edges have passed since reset for the synchronizer to be filled with real samples. The checker waits out a fixed warm-up count after reset for this. The stimulus changes pins and the write strobe only at falling edges, holds all pins low while reset is released, and issues no write until the synchronizer has settled.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  // Width of one trigger-mode field inside its slot.
  localparam int MODE_W = 3;

  // Upper two mode bits select the detection class.
  localparam logic [1:0] CLS_LEVEL = 2'b00;
  localparam logic [1:0] CLS_FALL  = 2'b01;
  localparam logic [1:0] CLS_RISE  = 2'b10;

  // Request for one pin from its mode, current and previous sample.
  function automatic logic trig_eval(input logic [MODE_W-1:0] mode,
                                     input logic cur,
                                     input logic prev);
    logic hit;
    case (mode[MODE_W-1:1])
      CLS_LEVEL: hit = mode[0] ? cur : ~cur;
      CLS_FALL:  hit = prev & ~cur;
      CLS_RISE:  hit = ~prev & cur;
      default:   hit = prev ^ cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/eirq_rst_sync.sv
module eirq_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/eirq_pin_sync.sv
module eirq_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q, cur_q, prev_q;
  logic [WIDTH-1:0] meta_d, cur_d, prev_d;

  // Next-state: shift the pin through two sync stages and one history stage.
  always_comb begin
    meta_d = pin_async;
    cur_d  = meta_q;
    prev_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/eirq_cfg_reg.sv
module eirq_cfg_reg #(
  parameter int NUM_PINS = 8,
  parameter int SLOT_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [NUM_PINS*SLOT_W-1:0]   wdata,
  output logic [NUM_PINS*SLOT_W-1:0]   cfg_o
);
  import eirq_pkg::*;

  localparam int CFG_W = NUM_PINS * SLOT_W;

  // Keep only the mode bits of each slot; spare bits stay zero.
  function automatic logic [CFG_W-1:0] field_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      m[p*SLOT_W +: MODE_W] = '1;
    end
    return m;
  endfunction

  localparam logic [CFG_W-1:0] KEEP_MASK = field_mask();

  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/eirq_trig_detect.sv
module eirq_trig_detect (
  input  logic [eirq_pkg::MODE_W-1:0] mode_i,
  input  logic                        cur_i,
  input  logic                        prev_i,
  output logic                        req_o
);
  import eirq_pkg::*;

  always_comb begin
    req_o = trig_eval(mode_i, cur_i, prev_i);
  end

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger #(
  parameter int NUM_PINS = 8,
  parameter int SLOT_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_in,
  input  logic                       cfg_wr_en,
  input  logic [NUM_PINS*SLOT_W-1:0] cfg_wdata,
  output logic [NUM_PINS*SLOT_W-1:0] cfg_rd_data,
  output logic [NUM_PINS-1:0]        irq_req
);
  import eirq_pkg::*;

  localparam int CFG_W = NUM_PINS * SLOT_W;

  logic                rst_n_int;
  logic [CFG_W-1:0]    cfg_word;
  logic [NUM_PINS-1:0] pin_cur, pin_prev;

  eirq_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  eirq_cfg_reg #(
    .NUM_PINS (NUM_PINS),
    .SLOT_W   (SLOT_W)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .cfg_o (cfg_word)
  );

  eirq_pin_sync #(
    .WIDTH (NUM_PINS)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pin_async (pin_in),
    .cur_o     (pin_cur),
    .prev_o    (pin_prev)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    eirq_trig_detect u_det (
      .mode_i (cfg_word[g*SLOT_W +: MODE_W]),
      .cur_i  (pin_cur[g]),
      .prev_i (pin_prev[g]),
      .req_o  (irq_req[g])
    );
  end

  assign cfg_rd_data = cfg_word;

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int NUM_PINS = 8,
  parameter int SLOT_W   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PINS-1:0]        pin_in,
  input logic                       cfg_wr_en,
  input logic [NUM_PINS*SLOT_W-1:0] cfg_wdata,
  input logic [NUM_PINS*SLOT_W-1:0] cfg_rd_data,
  input logic [NUM_PINS-1:0]        irq_req
);
  localparam int CFG_W = NUM_PINS * SLOT_W;

  function automatic logic [CFG_W-1:0] spare_bits();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      m[p*SLOT_W + SLOT_W - 1] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [CFG_W-1:0] SPARE = spare_bits();

  // Warm-up counter: history checks start once the pipeline holds real samples.
  logic [2:0] warm_q;
  logic       alive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= 3'd0;
    end else if (warm_q != 3'd7) begin
      warm_q <= warm_q + 3'd1;
    end
  end

  assign alive = (warm_q == 3'd7);

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & SPARE) == '0); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alive && cfg_wr_en) |=> (cfg_rd_data == ($past(cfg_wdata) & ~SPARE))); // R3

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alive && !cfg_wr_en) |=> $stable(cfg_rd_data)); // R3

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    logic [2:0] mode;
    assign mode = cfg_rd_data[g*SLOT_W +: 3];

    AST_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && mode == 3'b000) |-> (irq_req[g] == !$past(pin_in[g], 2))); // R4

    AST_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && mode == 3'b001) |-> (irq_req[g] == $past(pin_in[g], 2))); // R9

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && !cfg_wr_en && irq_req[g] && (mode[2:1] == 2'b01 || mode[2:1] == 2'b10))
        |=> !irq_req[g]); // R7

    AST_QUIET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (alive && mode[2:1] != 2'b00 && $past(pin_in[g], 2) == $past(pin_in[g], 3))
        |-> !irq_req[g]); // R10
  end

endmodule

bind ext_irq_trigger eirq_checker #(
  .NUM_PINS (NUM_PINS),
  .SLOT_W   (SLOT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_in      (pin_in),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wdata   (cfg_wdata),
  .cfg_rd_data (cfg_rd_data),
  .irq_req     (irq_req)
);

// File: tb/sim_ext_irq_trigger.sv
module sim_ext_irq_trigger;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIELD_MASK = 32'h7777_7777;

  logic        clk;
  logic        rst_n;
  logic [7:0]  pin;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rd;
  logic [7:0]  irq;

  int checks = 0;
  int fails  = 0;
  int pulse_cnt [8];

  // Behavioural model state: pin values seen at each rising edge, newest first.
  logic [7:0]  hist [$];
  logic [31:0] exp_cfg;

  ext_irq_trigger u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin),
    .cfg_wr_en   (wr),
    .cfg_wdata   (wdata),
    .cfg_rd_data (rd),
    .irq_req     (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_irq();
    logic [7:0] r;
    logic c, p;
    logic [2:0] m;
    for (int i = 0; i < 8; i++) begin
      m = exp_cfg[4*i +: 3];
      c = hist[1][i];
      p = hist[2][i];
      if (m == 3'b000)      r[i] = !c;
      else if (m == 3'b001) r[i] = c;
      else if (m[2:1] == 2'b01) r[i] = p && !c;
      else if (m[2:1] == 2'b10) r[i] = !p && c;
      else                  r[i] = p != c;
    end
    return r;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, advance the model at the rising
  // edge, compare at the next falling edge.
  task automatic step(input logic [7:0] p, input logic w, input logic [31:0] d, input string tag);
    pin = p; wr = w; wdata = d;
    @(posedge clk);
    hist.push_front(pin);
    if (hist.size() > 4) void'(hist.pop_back());
    if (w) exp_cfg = d & FIELD_MASK;
    @(negedge clk);
    wr = 1'b0;
    check32({tag, " cfg"}, rd, exp_cfg);
    check32({tag, " irq"}, {24'h0, irq}, {24'h0, model_irq()});
    for (int i = 0; i < 8; i++) if (irq[i]) pulse_cnt[i]++;
  endtask

  task automatic hold(input logic [7:0] p, input int n, input string tag);
    for (int k = 0; k < n; k++) step(p, 1'b0, 32'h0, tag);
  endtask

  task automatic clear_pulses();
    for (int i = 0; i < 8; i++) pulse_cnt[i] = 0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] word;
    logic [7:0]  patt;
    rst_n = 1'b0; pin = 8'h00; wr = 1'b0; wdata = 32'h0;
    exp_cfg = 32'h0;
    for (int k = 0; k < 4; k++) hist.push_front(8'h00);
    clear_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(8'h00, 6, "R1 settle");
    // R1: reset state
    check32("R1 cfg reset", rd, 32'h0);
    check32("R1 low default", {24'h0, irq}, 32'h0000_00FF);

    // R2: spare bits discarded
    step(8'h00, 1'b1, 32'hFFFF_FFFF, "R2 write all ones");
    check32("R2 spare bits read zero", rd, 32'h7777_7777);
    step(8'h00, 1'b1, 32'h8888_8888, "R2 write spare only");
    check32("R2 spare only", rd, 32'h0);

    // R3: read-modify-write of pin 3 keeps other fields
    step(8'h00, 1'b1, 32'h1357_2461, "R3 full write");
    check32("R3 readback", rd, 32'h1357_2461);
    word = (rd & ~(32'h7 << 12)) | (32'h4 << 12);
    step(8'h00, 1'b1, word, "R3 rmw");
    check32("R3 rmw others kept", rd, 32'h1357_4461);
    hold(8'h00, 3, "R3 hold");
    check32("R3 holds without write", rd, 32'h1357_4461);

    // R5 and R9: high level, latency of two edges
    step(8'h00, 1'b1, 32'h1111_1111, "R5 set high");
    hold(8'h00, 3, "R5 idle");
    step(8'hFF, 1'b0, 32'h0, "R9 first edge");
    check32("R9 not yet after one edge", {24'h0, irq}, 32'h0);
    step(8'hFF, 1'b0, 32'h0, "R9 second edge");
    check32("R9 visible after two edges", {24'h0, irq}, 32'h0000_00FF);
    hold(8'hA5, 3, "R5 pattern A5");
    hold(8'h5A, 3, "R5 pattern 5A");
    check32("R5 high level", {24'h0, irq}, 32'h0000_005A);

    // R4: low level
    step(8'h5A, 1'b1, 32'h0, "R4 set low");
    hold(8'h3C, 3, "R4 pattern 3C");
    check32("R4 low level", {24'h0, irq}, 32'h0000_00C3);

    // R6: falling edge, both encodings
    step(8'hFF, 1'b1, 32'h3232_3232, "R6 set fall");
    hold(8'hFF, 3, "R6 high");
    clear_pulses();
    hold(8'h00, 4, "R6 fall");
    hold(8'hFF, 4, "R6 rise ignored");
    for (int i = 0; i < 8; i++) check_int($sformatf("R6 pulses pin%0d", i), pulse_cnt[i], 1);

    // R7: rising edge, both encodings
    step(8'h00, 1'b1, 32'h5454_5454, "R7 set rise");
    hold(8'h00, 3, "R7 low");
    clear_pulses();
    hold(8'hFF, 4, "R7 rise");
    hold(8'h00, 4, "R7 fall ignored");
    for (int i = 0; i < 8; i++) check_int($sformatf("R7 pulses pin%0d", i), pulse_cnt[i], 1);

    // R8: both edges, including back-to-back toggles
    step(8'h00, 1'b1, 32'h7676_7676, "R8 set both");
    hold(8'h00, 3, "R8 low");
    clear_pulses();
    for (int k = 0; k < 4; k++) step((k % 2 == 0) ? 8'hFF : 8'h00, 1'b0, 32'h0, "R8 toggle");
    hold(8'h00, 4, "R8 settle");
    for (int i = 0; i < 8; i++) check_int($sformatf("R8 pulses pin%0d", i), pulse_cnt[i], 4);

    // R10: mode changes on quiet pins give no pulse
    hold(8'hA5, 4, "R10 quiet");
    clear_pulses();
    for (int m = 2; m < 8; m++) begin
      word = 32'h0;
      for (int i = 0; i < 8; i++) word[4*i +: 3] = m[2:0];
      step(8'hA5, 1'b1, word, "R10 mode change");
    end
    hold(8'hA5, 2, "R10 after");
    for (int i = 0; i < 8; i++) check_int($sformatf("R10 pulses pin%0d", i), pulse_cnt[i], 0);

    // R11: mixed per-pin modes with a varying pattern
    step(8'hA5, 1'b1, 32'h7654_3210, "R11 mixed modes");
    patt = 8'h1D;
    for (int k = 0; k < 40; k++) begin
      patt = {patt[6:0], patt[7] ^ patt[5] ^ patt[4] ^ patt[3]};
      step(patt, 1'b0, 32'h0, "R11 mixed");
    end
    step(patt, 1'b1, 32'h0765_4321, "R11 shifted modes");
    for (int k = 0; k < 40; k++) begin
      patt = {patt[6:0], patt[7] ^ patt[5] ^ patt[4] ^ patt[3]};
      step(patt, 1'b0, 32'h0, "R11 shifted");
    end

    finish_run();
  end

endmodule